// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block holds a small switch forwarding table and a command engine that maintains it. Each slot stores a 48-bit station address and a 32-bit attribute word that carries a destination port bitmap, four action flags, a priority with its enable, and a two-bit status. Software reaches the engine through one write port that selects one of three data words or the command word. The three data words are always visible on output buses.

An operation starts when the command word is written with its go bit set. The engine then walks every slot once, from index 0 upward, and in a final cycle commits the result. The result may be a slot write, a write-back of an entry into the data words, and the violation flag. The violation flag means "table full" after a load and "nothing matched" after a purge or a port flush. Software polls the busy output and then reads the data words and the flag.

Top module: `mac_table_engine`

## Requirements
- R1: After reset the three data words read zero, busy and violation read 0, and every slot is empty (status 0).
- R2: A write to command selector 3 with bit 31 set starts function code bits [2:0] when the engine is idle. Busy reads 1 from the next cycle for exactly DEPTH+1 cycles and then returns to 0. A command write with bit 31 clear, or any command write while busy is 1, starts nothing.
- R3: Writes to data selectors 0, 1 and 2 update the word when busy is 0 and are ignored when busy is 1, including the last busy cycle.
- R4: The key address is word1[31:0] followed by word0[31:16]. Address byte 0 is word1[31:24] and byte 5 is word0[23:16]. Entries written back use this layout, with word0[15:0] zero.
- R5: Word 2 holds the port bitmap in bits [PORTS-1:0] and copy-to-CPU, redirect-to-CPU, source-drop and mirror flags in bits 8 to 11. It holds priority enable in bit 12, priority in [14:13] and status in [17:16]. A load stores only these bits. Status 1 (static) is kept and any other value is stored as 2 (dynamic).
- R6: Load (code 2) overwrites the occupied slot that has the same address, or else fills the lowest empty slot. With neither available it sets violation and leaves the table unchanged.
- R7: Purge (code 3) empties the slot that holds the key and writes that entry back into the data words. If no slot matches, it sets violation and leaves the words unchanged.
- R8: Flush-all (code 1) empties every slot.
- R9: Flush-dynamic (code 4) empties only slots with status 2 and keeps static ones.
- R10: Port flush (code 5) reads a port number from word0[2:0] and empties every occupied slot whose bitmap has that bit set. If no slot matches, or the number is PORTS or above, it sets violation.
- R11: Get-next (code 6) writes back the lowest occupied slot after the slot holding the key, or the lowest occupied slot when the key is zero. If there is none, or the key is absent, it writes all three words to zero.
- R12: Violation clears when an operation starts. Codes 0, 1, 4, 6 and 7 always finish with violation 0, and codes 0 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0..2 data word, 3 command word |
| wr_data | input | 32 | Write data |
| word0_o | output | 32 | Data word 0 |
| word1_o | output | 32 | Data word 1 |
| word2_o | output | 32 | Data word 2 |
| busy_o | output | 1 | Operation in progress |
| viol_o | output | 1 | Full / not-found indication of the last operation |

## Verification
Two things can fall on the same clock edge: the engine's write-back into the data words, and a software write to those words. The bench provokes this by driving a word-2 write exactly on the last busy cycle of a get-next. It expects the engine's result to win and the software value to be lost. It also sends a second command one cycle after a start and checks afterwards, by iterating the table, that the second command did not run.

// File: rtl/mat_pkg.sv
package mat_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_FLUSH_ALL  = 3'd1,
    OP_LOAD       = 3'd2,
    OP_PURGE      = 3'd3,
    OP_FLUSH_DYN  = 3'd4,
    OP_FLUSH_PORT = 3'd5,
    OP_NEXT       = 3'd6,
    OP_RSVD       = 3'd7
  } op_e;

  typedef struct packed {
    logic [47:0] mac;
    logic [31:0] attr;
  } slot_t;

  localparam logic [1:0] ST_EMPTY  = 2'd0;
  localparam logic [1:0] ST_STATIC = 2'd1;
  localparam logic [1:0] ST_DYN    = 2'd2;

  // Search key: word1 carries the upper four bytes, word0 the lower two.
  function automatic logic [47:0] key_of(input logic [31:0] w0, input logic [31:0] w1);
    return {w1, w0[31:16]};
  endfunction

  function automatic logic [1:0] status_of(input logic [31:0] attr);
    return attr[17:16];
  endfunction

  // Keep bitmap and flag bits, force status to static or dynamic.
  function automatic logic [31:0] attr_norm(input logic [31:0] w2, input int ports);
    logic [31:0] keep;
    logic [31:0] res;
    keep = ((32'h1 << ports) - 32'h1) | 32'h0000_7F00;
    res  = w2 & keep;
    res[17:16] = (w2[17:16] == ST_STATIC) ? ST_STATIC : ST_DYN;
    return res;
  endfunction

endpackage

// File: rtl/mat_regs.sv
module mat_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        busy_i,
  input  logic        wb_en_i,
  input  logic [31:0] wb_w0_i,
  input  logic [31:0] wb_w1_i,
  input  logic [31:0] wb_w2_i,
  output logic        start_o,
  output logic [2:0]  func_o,
  output logic [31:0] w0_o,
  output logic [31:0] w1_o,
  output logic [31:0] w2_o
);

  logic sw_write;
  assign sw_write = wr_en && !busy_i && (wr_sel != 2'd3);
  assign start_o  = wr_en && !busy_i && (wr_sel == 2'd3) && wr_data[31];
  assign func_o   = wr_data[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0_o <= '0;
      w1_o <= '0;
      w2_o <= '0;
    end else if (wb_en_i) begin
      w0_o <= wb_w0_i;
      w1_o <= wb_w1_i;
      w2_o <= wb_w2_i;
    end else if (sw_write) begin
      case (wr_sel)
        2'd0:    w0_o <= wr_data;
        2'd1:    w1_o <= wr_data;
        default: w2_o <= wr_data;
      endcase
    end
  end

  // R3
  words_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !wb_en_i) |=> ($stable(w0_o) && $stable(w1_o) && $stable(w2_o)));

endmodule

// File: rtl/mat_table.sv
module mat_table #(
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    rd_idx,
  output mat_pkg::slot_t   rd_slot,
  input  logic             we,
  input  logic [IW-1:0]    wr_idx,
  input  mat_pkg::slot_t   wr_slot
);

  mat_pkg::slot_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_slot;
    end
  end

  assign rd_slot = mem[rd_idx];

endmodule

// File: rtl/mat_seq.sv
module mat_seq
  import mat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PORTS = 7,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    func_i,
  input  logic [47:0]   key_i,
  input  logic [2:0]    port_i,
  input  logic [31:0]   w2_i,
  input  slot_t         rd_slot_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          tbl_we_o,
  output logic [IW-1:0] tbl_idx_o,
  output slot_t         tbl_slot_o,
  output logic          busy_o,
  output logic          viol_o,
  output logic          wb_en_o,
  output logic [31:0]   wb_w0_o,
  output logic [31:0]   wb_w1_o,
  output logic [31:0]   wb_w2_o
);

  localparam int CW = $clog2(DEPTH + 2) + 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DONE} state_e;

  state_e        state_q;
  op_e           op_q;
  logic [IW-1:0] idx_q, hit_idx_q, free_idx_q;
  logic          hit_q, free_q, seen_q;
  slot_t         ent_q;
  logic [CW-1:0] busy_cnt_q;

  // Named per-slot events of the scan
  logic slot_occ, slot_hit, port_in, scan_clear, ld_ok, in_scan, in_done;
  assign in_scan  = (state_q == S_SCAN);
  assign in_done  = (state_q == S_DONE);
  assign slot_occ = status_of(rd_slot_i.attr) != ST_EMPTY;
  assign slot_hit = slot_occ && (rd_slot_i.mac == key_i);
  assign port_in  = (32'(port_i) < PORTS) && rd_slot_i.attr[port_i];
  assign ld_ok    = hit_q || free_q;

  always_comb begin
    scan_clear = 1'b0;
    if (in_scan) begin
      case (op_q)
        OP_FLUSH_ALL:  scan_clear = 1'b1;
        OP_FLUSH_DYN:  scan_clear = status_of(rd_slot_i.attr) == ST_DYN;
        OP_PURGE:      scan_clear = slot_hit;
        OP_FLUSH_PORT: scan_clear = slot_occ && port_in;
        default:       scan_clear = 1'b0;
      endcase
    end
  end

  assign rd_idx_o   = idx_q;
  assign busy_o     = (state_q != S_IDLE);
  assign tbl_we_o   = scan_clear || (in_done && op_q == OP_LOAD && ld_ok);
  assign tbl_idx_o  = in_done ? (hit_q ? hit_idx_q : free_idx_q) : idx_q;
  assign tbl_slot_o = in_done ? slot_t'{mac: key_i, attr: attr_norm(w2_i, PORTS)} : '0;

  assign wb_en_o = in_done && ((op_q == OP_PURGE && hit_q) || op_q == OP_NEXT);
  assign wb_w0_o = {ent_q.mac[15:0], 16'h0000};
  assign wb_w1_o = ent_q.mac[47:16];
  assign wb_w2_o = ent_q.attr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      op_q       <= OP_NONE;
      idx_q      <= '0;
      hit_idx_q  <= '0;
      free_idx_q <= '0;
      hit_q      <= 1'b0;
      free_q     <= 1'b0;
      seen_q     <= 1'b0;
      ent_q      <= '0;
      viol_o     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_SCAN;
          op_q    <= op_e'(func_i);
          idx_q   <= '0;
          hit_q   <= 1'b0;
          free_q  <= 1'b0;
          seen_q  <= (key_i == 48'h0);
          ent_q   <= '0;
          viol_o  <= 1'b0;
        end
        S_SCAN: begin
          case (op_q)
            OP_LOAD: begin
              if (slot_hit && !hit_q) begin
                hit_q     <= 1'b1;
                hit_idx_q <= idx_q;
              end
              if (!slot_occ && !free_q) begin
                free_q     <= 1'b1;
                free_idx_q <= idx_q;
              end
            end
            OP_PURGE: if (slot_hit) begin
              hit_q <= 1'b1;
              ent_q <= rd_slot_i;
            end
            OP_FLUSH_PORT: if (slot_occ && port_in) hit_q <= 1'b1;
            OP_NEXT: begin
              if (seen_q && slot_occ && !hit_q) begin
                hit_q <= 1'b1;
                ent_q <= rd_slot_i;
              end
              if (slot_hit) seen_q <= 1'b1;
            end
            default: ;
          endcase
          if (idx_q == LAST) state_q <= S_DONE;
          else idx_q <= idx_q + 1'b1;
        end
        default: begin
          state_q <= S_IDLE;
          viol_o  <= (op_q == OP_LOAD && !ld_ok) ||
                     ((op_q == OP_PURGE || op_q == OP_FLUSH_PORT) && !hit_q);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy_o) busy_cnt_q <= CW'(1);
    else busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  // R2
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_cnt_q <= CW'(DEPTH + 1)));

  // R2
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |=> !busy_o);

  // R12
  viol_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_o) |-> (op_q == OP_LOAD || op_q == OP_PURGE || op_q == OP_FLUSH_PORT));

  // R7
  purge_wb_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && op_q == OP_PURGE) |-> (wb_w2_o[17:16] != ST_EMPTY));

  // R2
  table_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we_o |-> busy_o);

endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine #(
  parameter int DEPTH = 16,
  parameter int PORTS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] word0_o,
  output logic [31:0] word1_o,
  output logic [31:0] word2_o,
  output logic        busy_o,
  output logic        viol_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic           start, tbl_we, wb_en;
  logic [2:0]     func;
  logic [IW-1:0]  rd_idx, tbl_idx;
  logic [31:0]    wb_w0, wb_w1, wb_w2;
  mat_pkg::slot_t rd_slot, tbl_slot;

  mat_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy_i(busy_o), .wb_en_i(wb_en), .wb_w0_i(wb_w0), .wb_w1_i(wb_w1), .wb_w2_i(wb_w2),
    .start_o(start), .func_o(func), .w0_o(word0_o), .w1_o(word1_o), .w2_o(word2_o)
  );

  mat_table #(.DEPTH(DEPTH), .IW(IW)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_slot(rd_slot),
    .we(tbl_we), .wr_idx(tbl_idx), .wr_slot(tbl_slot)
  );

  mat_seq #(.DEPTH(DEPTH), .PORTS(PORTS), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .func_i(func),
    .key_i(mat_pkg::key_of(word0_o, word1_o)), .port_i(word0_o[2:0]), .w2_i(word2_o),
    .rd_slot_i(rd_slot), .rd_idx_o(rd_idx), .tbl_we_o(tbl_we), .tbl_idx_o(tbl_idx),
    .tbl_slot_o(tbl_slot), .busy_o(busy_o), .viol_o(viol_o), .wb_en_o(wb_en),
    .wb_w0_o(wb_w0), .wb_w1_o(wb_w1), .wb_w2_o(wb_w2)
  );

endmodule

// File: tb/mac_table_engine_test.sv
module mac_table_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PORTS = 7;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] word0_o, word1_o, word2_o;
  logic busy_o, viol_o;
  int checks = 0, errors = 0;

  mac_table_engine #(.DEPTH(DEPTH), .PORTS(PORTS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .word0_o(word0_o), .word1_o(word1_o), .word2_o(word2_o), .busy_o(busy_o), .viol_o(viol_o));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [47:0] m_mac [DEPTH];
  logic [31:0] m_attr [DEPTH];
  logic [31:0] m_w0 = 0, m_w1 = 0, m_w2 = 0, p_w0, p_w1, p_w2;
  bit m_busy = 0, m_viol = 0, p_viol, p_wb;
  int m_cnt = 0;

  function automatic logic [31:0] ref_norm(input logic [31:0] w);
    logic [31:0] r;
    r = w & (32'h7F00 | ((32'h1 << PORTS) - 1));
    r[17:16] = (w[17:16] == 2'd1) ? 2'd1 : 2'd2;
    return r;
  endfunction

  task automatic ref_op(input logic [2:0] code);
    logic [47:0] key;
    int hit, free, start;
    key = {m_w1, m_w0[31:16]};
    hit = -1; free = -1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (m_attr[i][17:16] != 0 && m_mac[i] == key) hit = i;
      if (m_attr[i][17:16] == 0) free = i;
    end
    p_viol = 0; p_wb = 0;
    case (code)
      3'd1: for (int i = 0; i < DEPTH; i++) m_attr[i] = 0;
      3'd2: begin
        if (hit < 0) hit = free;
        if (hit < 0) p_viol = 1;
        else begin m_mac[hit] = key; m_attr[hit] = ref_norm(m_w2); end
      end
      3'd3: if (hit < 0) p_viol = 1;
        else begin
          p_wb = 1; p_w1 = key[47:16]; p_w0 = {key[15:0], 16'h0}; p_w2 = m_attr[hit];
          m_attr[hit] = 0; m_mac[hit] = 0;
        end
      3'd4: for (int i = 0; i < DEPTH; i++)
              if (m_attr[i][17:16] == 2) begin m_attr[i] = 0; m_mac[i] = 0; end
      3'd5: begin
        p_viol = 1;
        for (int i = 0; i < DEPTH; i++)
          if (m_attr[i][17:16] != 0 && int'(m_w0[2:0]) < PORTS && m_attr[i][m_w0[2:0]]) begin
            m_attr[i] = 0; m_mac[i] = 0; p_viol = 0;
          end
      end
      3'd6: begin
        p_wb = 1; p_w0 = 0; p_w1 = 0; p_w2 = 0;
        start = (key == 0) ? 0 : ((hit < 0) ? DEPTH : hit + 1);
        for (int i = DEPTH - 1; i >= start; i--)
          if (m_attr[i][17:16] != 0) begin
            p_w1 = m_mac[i][47:16]; p_w0 = {m_mac[i][15:0], 16'h0}; p_w2 = m_attr[i];
          end
      end
      default: ;
    endcase
    m_busy = 1; m_cnt = DEPTH + 1; m_viol = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_viol = 0; m_w0 = 0; m_w1 = 0; m_w2 = 0;
      for (int i = 0; i < DEPTH; i++) begin m_mac[i] = 0; m_attr[i] = 0; end
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_viol = p_viol;
        if (p_wb) begin m_w0 = p_w0; m_w1 = p_w1; m_w2 = p_w2; end
      end
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: m_w0 = wr_data;
        2'd1: m_w1 = wr_data;
        2'd2: m_w2 = wr_data;
        default: if (wr_data[31]) ref_op(wr_data[2:0]);
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) if (rst_n) begin
    check("R2 busy", 32'(busy_o), 32'(m_busy));
    check("R12 viol", 32'(viol_o), 32'(m_viol));
    check("R3 word0", word0_o, m_w0);
    check("R3 word1", word1_o, m_w1);
    check("R3 word2", word2_o, m_w2);
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic op(input logic [2:0] code);
    wr(2'd3, 32'h8000_0000 | 32'(code));
    while (busy_o) @(negedge clk);
  endtask

  task automatic set_key(input logic [31:0] w1, input logic [31:0] w0);
    wr(2'd1, w1); wr(2'd0, w0);
  endtask

  task automatic load(input logic [31:0] w1, input logic [31:0] w0, input logic [31:0] w2);
    set_key(w1, w0); wr(2'd2, w2); op(3'd2);
  endtask

  task automatic expect3(input string tag, input logic [31:0] e0, input logic [31:0] e1,
                         input logic [31:0] e2);
    check(tag, word0_o, e0); check(tag, word1_o, e1); check(tag, word2_o, e2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy_o), 0); check("R1 viol", 32'(viol_o), 0);
    expect3("R1 words", 0, 0, 0);
    op(3'd6);
    expect3("R1 empty table next", 0, 0, 0);

    // R4 R5 R6 loads
    load(32'h0211_2233, 32'h4455_0000, 32'h0001_0805);
    check("R6 load viol", 32'(viol_o), 0);
    load(32'h0A00_0000, 32'h0001_0000, 32'h0002_0102);
    load(32'h0C00_0000, 32'h0002_0000, 32'h8000_7004);
    set_key(0, 0); op(3'd6);
    expect3("R4 R11 first entry", 32'h4455_0000, 32'h0211_2233, 32'h0001_0805);
    op(3'd6);
    expect3("R11 second entry", 32'h0001_0000, 32'h0A00_0000, 32'h0002_0102);
    op(3'd6);
    expect3("R5 normalized attr", 32'h0002_0000, 32'h0C00_0000, 32'h0002_7004);
    op(3'd6);
    expect3("R11 end of table", 0, 0, 0);
    check("R12 next viol", 32'(viol_o), 0);

    // R6 overwrite
    load(32'h0211_2233, 32'h4455_0000, 32'h0001_1001);
    set_key(0, 0); op(3'd6);
    expect3("R6 overwrite in place", 32'h4455_0000, 32'h0211_2233, 32'h0001_1001);

    // R7 purge
    set_key(32'h0A00_0000, 32'h0001_0000); op(3'd3);
    check("R7 purge viol", 32'(viol_o), 0);
    check("R7 purge wb", word2_o, 32'h0002_0102);
    op(3'd3);
    check("R7 purge miss viol", 32'(viol_o), 1);
    check("R7 purge miss words", word1_o, 32'h0A00_0000);

    // R10 port flush
    wr(2'd0, 32'h0000_0002); op(3'd5);
    check("R10 flush port hit", 32'(viol_o), 0);
    op(3'd5);
    check("R10 flush port miss", 32'(viol_o), 1);
    wr(2'd0, 32'h0000_0007); op(3'd5);
    check("R10 port out of range", 32'(viol_o), 1);
    set_key(0, 0); op(3'd6); op(3'd6);
    expect3("R10 entry removed", 0, 0, 0);

    // R2 no-go command and command while busy
    wr(2'd3, 32'h0000_0001);
    check("R2 go bit clear", 32'(busy_o), 0);
    set_key(0, 0);
    wr(2'd3, 32'h8000_0006);
    wr(2'd3, 32'h8000_0001);
    while (busy_o) @(negedge clk);
    check("R2 busy cmd ignored", word1_o, 32'h0211_2233);

    // R3 write on the final busy cycle collides with write-back
    set_key(0, 0);
    wr(2'd3, 32'h8000_0006);
    wr(2'd0, 32'h1234_5678);
    repeat (DEPTH - 2) @(negedge clk);
    wr_en = 1; wr_sel = 2'd2; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); wr_en = 0;
    check("R3 last busy write dropped", word2_o, 32'h0001_1001);
    check("R2 busy released", 32'(busy_o), 0);

    // R8 flush all, then fill to capacity
    op(3'd1);
    set_key(0, 0); op(3'd6);
    expect3("R8 flush all", 0, 0, 0);
    for (int i = 0; i < DEPTH; i++)
      load(32'h1000_0000, {8'h00, 8'(i + 1), 16'h0}, (i % 2 == 0) ? 32'h0001_0001 : 32'h0002_0001);
    check("R6 last slot", 32'(viol_o), 0);
    load(32'h1000_0000, {8'h00, 8'(DEPTH + 1), 16'h0}, 32'h0001_0001);
    check("R6 table full", 32'(viol_o), 1);

    // R9 flush dynamic keeps static
    op(3'd4);
    check("R12 flush dyn viol", 32'(viol_o), 0);
    set_key(0, 0);
    for (int i = 0; i < DEPTH; i += 2) begin
      op(3'd6);
      check("R9 static kept", word0_o, {8'h00, 8'(i + 1), 16'h0});
    end
    op(3'd6);
    expect3("R9 dynamic gone", 0, 0, 0);

    // R12 unused codes
    load(32'h0211_2233, 32'h4455_0000, 32'h0001_0805);
    op(3'd7); check("R12 code 7", 32'(viol_o), 0);
    op(3'd0); check("R12 code 0", 32'(viol_o), 0);
    op(3'd1); set_key(0, 0); op(3'd6);
    expect3("R8 flush all again", 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule